// File: doc/BRIEF.md
# Stuck-at Test Vector Generator

This block searches for an input vector that exposes one single stuck-at fault in a small combinational netlist without fanout. The netlist sits in an internal table of gates that is written one entry at a time through a configuration port. Each entry names the gate kind, up to two source lines, the gate that its output feeds (its sink), and whether its output is a primary output. The index of an entry is also the index of the line that the gate drives, and primary inputs are entries of kind PI.

A start pulse supplies the faulty line and the value it is stuck at. The engine clears every line to unassigned, sets the faulty line to the complement of the stuck value, and then carries the error (good 1 / faulty 0, or the reverse) forward through the sink chain until it reaches a primary output. Each side input it passes is driven to the non-controlling value of its gate. All pending work lives on an explicit stack, and the engine handles one entry per clock. When the stack empties, the run ends with a one-cycle done pulse, and the result bus holds a two-bit code per line. A run that meets a value conflict, a dead end or a full stack ends with fail set.

Top module: `atpg_engine`

## Requirements
- R1: After reset, busy, done and fail are 0, and every two-bit slot of result reads 2'b10.
- R2: A write with cfg_we stores kind, sources, sink and output flag at entry cfg_addr. The kind codes are 0 PI, 1 AND, 2 OR, 3 NAND, 4 NOR, 5 NOT. After reset every entry is kind PI, with sink 0 and the output flag clear.
- R3: Each start sets every line back to unassigned, so a primary input that the previous run assigned reads 2'b10 unless the new run assigns it.
- R4: For a line stuck at v, the line is first justified to the complement of v. The error then carried forward has good value 1 and faulty value 0 when v is 0, and the reverse when v is 1.
- R5: Justifying a gate output to val requires val XOR inversion on the inputs. The inversion is 1 for NAND, NOR and NOT. When that value is the non-controlling value, both inputs are justified to it. A NOT gate always justifies its single input (src0). Justification stops at a PI line, which takes the value.
- R6: When the required input value is the controlling value (0 for AND and NAND, 1 for OR and NOR), only one input is justified. It is the lower-indexed source that is still unassigned, or src0 if neither source is unassigned.
- R7: Carrying the error into the sink gate first justifies the other input of that gate to its non-controlling value. The sink output then takes the error, inverted when the sink inverts.
- R8: A run that reaches a primary output and empties its stack ends with done high for exactly one cycle and fail 0.
- R9: Carrying the error from a line that is not a primary output into a sink entry of kind PI sets fail and ends the run.
- R10: Assigning a line that holds a value with a different good component sets fail and ends the run.
- R11: A step whose pushes would take the stack beyond STACK_DEPTH entries sets fail and ends the run.
- R12: A PI slot of result reads 2'b00 for good value 0, 2'b01 for good value 1, and 2'b10 when the line is unassigned. Slots of non-PI entries read 2'b10.
- R13: busy is 1 in the cycle after an accepted start and stays 1 until the cycle done is high. done is 0 again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | IW | Entry (line) index to write |
| cfg_kind | input | 3 | Gate kind code |
| cfg_src0 | input | IW | First source line |
| cfg_src1 | input | IW | Second source line (ignored for NOT and PI) |
| cfg_sink | input | IW | Gate that this line feeds |
| cfg_is_out | input | 1 | Line is a primary output |
| start | input | 1 | Begin a run (taken when not busy) |
| fault_line | input | IW | Line carrying the stuck-at fault |
| stuck_val | input | 1 | Stuck value of the fault |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run found no vector |
| result | output | 2*NG | Per-line value codes, line i at bits 2i+1:2i |

## Verification
The bench applies both stuck values to a PI, to the inner gates and to the primary output. It checks that an input the search does not need stays 2'b10. A design that kept values between runs would leave an input assigned from the previous run, and one that picked the wrong input for a controlling requirement would assign the wrong input. A design with swapped error polarity or wrong inversion would justify side inputs to the wrong value, and the vector would disagree. The error paths are driven on purpose: a sink entry of kind PI, a rewired netlist where one input feeds two gates and the values conflict, and a second instance with a two-entry stack that must overflow. A design that ignored any of these would report success.

// File: rtl/atpg_pkg.sv
package atpg_pkg;
  localparam logic [2:0] K_PI   = 3'd0;
  localparam logic [2:0] K_AND  = 3'd1;
  localparam logic [2:0] K_OR   = 3'd2;
  localparam logic [2:0] K_NAND = 3'd3;
  localparam logic [2:0] K_NOR  = 3'd4;
  localparam logic [2:0] K_NOT  = 3'd5;

  // composite good/faulty line values
  localparam logic [2:0] LV_0  = 3'd0;  // 0/0
  localparam logic [2:0] LV_1  = 3'd1;  // 1/1
  localparam logic [2:0] LV_D  = 3'd2;  // 1/0
  localparam logic [2:0] LV_DB = 3'd3;  // 0/1
  localparam logic [2:0] LV_X  = 3'd4;  // unassigned

  function automatic logic ctrl_of(input logic [2:0] k);
    return (k == K_OR) || (k == K_NOR);
  endfunction

  function automatic logic inv_of(input logic [2:0] k);
    return (k == K_NAND) || (k == K_NOR) || (k == K_NOT);
  endfunction

  function automatic logic good_of(input logic [2:0] v);
    return (v == LV_1) || (v == LV_D);
  endfunction

  function automatic logic is_err(input logic [2:0] v);
    return (v == LV_D) || (v == LV_DB);
  endfunction

  function automatic logic [2:0] flip_err(input logic [2:0] v);
    return (v == LV_D) ? LV_DB : LV_D;
  endfunction

  function automatic logic [2:0] lv_of_bit(input logic b);
    return b ? LV_1 : LV_0;
  endfunction

  function automatic logic [1:0] pi_code(input logic [2:0] v);
    if (v == LV_X) return 2'b10;
    return {1'b0, good_of(v)};
  endfunction
endpackage

// File: rtl/atpg_netlist.sv
module atpg_netlist #(
  parameter int NG = 16,
  parameter int IW = $clog2(NG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IW-1:0]          addr,
  input  logic [2:0]             kind_i,
  input  logic [IW-1:0]          src0_i,
  input  logic [IW-1:0]          src1_i,
  input  logic [IW-1:0]          sink_i,
  input  logic                   po_i,
  output logic [NG-1:0][2:0]     kind_q,
  output logic [NG-1:0][IW-1:0]  src0_q,
  output logic [NG-1:0][IW-1:0]  src1_q,
  output logic [NG-1:0][IW-1:0]  sink_q,
  output logic [NG-1:0]          po_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      src0_q <= '0;
      src1_q <= '0;
      sink_q <= '0;
      po_q   <= '0;
    end else if (we) begin
      kind_q[addr] <= kind_i;
      src0_q[addr] <= src0_i;
      src1_q[addr] <= src1_i;
      sink_q[addr] <= sink_i;
      po_q[addr]   <= po_i;
    end
  end
endmodule

// File: rtl/atpg_lines.sv
module atpg_lines #(
  parameter int NG = 16,
  parameter int IW = $clog2(NG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [IW-1:0]      waddr,
  input  logic [2:0]         wdata,
  output logic [NG-1:0][2:0] vals_q
);
  import atpg_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < NG; i++) vals_q[i] <= LV_X;
    end else if (we) begin
      vals_q[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/atpg_stack.sv
module atpg_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         pop,
  input  logic [1:0]   push_n,
  input  logic [W-1:0] push_a,
  input  logic [W-1:0] push_b,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int CW = $clog2(DEPTH + 3);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] sp, base, nxt;

  always_comb begin
    if (clear)    base = '0;
    else if (pop) base = sp - 1'b1;
    else          base = sp;
    nxt   = base + CW'(push_n);
    ovf_o = nxt > CW'(DEPTH);
  end

  assign empty_o = (sp == '0);
  assign top_o   = empty_o ? '0 : mem[AW'(sp - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n)      sp <= '0;
    else if (!ovf_o) sp <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!ovf_o) begin
      if (push_n != 2'd0) mem[AW'(base)] <= push_a;
      if (push_n == 2'd2) mem[AW'(base + 1'b1)] <= push_b;
    end
  end
endmodule

// File: rtl/atpg_engine.sv
module atpg_engine #(
  parameter int NG          = 16,
  parameter int STACK_DEPTH = 16,
  parameter int IW          = $clog2(NG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_addr,
  input  logic [2:0]      cfg_kind,
  input  logic [IW-1:0]   cfg_src0,
  input  logic [IW-1:0]   cfg_src1,
  input  logic [IW-1:0]   cfg_sink,
  input  logic            cfg_is_out,
  input  logic            start,
  input  logic [IW-1:0]   fault_line,
  input  logic            stuck_val,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [2*NG-1:0] result
);
  import atpg_pkg::*;
  localparam int SW = 1 + IW + 3;  // {is_prop, line, value}

  logic [NG-1:0][2:0]    kind_q;
  logic [NG-1:0][IW-1:0] src0_q, src1_q, sink_q;
  logic [NG-1:0]         po_q;
  logic [NG-1:0][2:0]    vals_q;

  logic          running, accept;
  logic [SW-1:0] top_e, push_a, push_b;
  logic [1:0]    push_n;
  logic          stk_empty, ovf_ev, step_act;
  logic          t_prop;
  logic [IW-1:0] t_line;
  logic [2:0]    t_val, cur, kd;
  logic          assign_ok, val_we, conflict_ev, dead_end_ev, fail_ev;
  logic          inval;
  logic [IW-1:0] a0, a1, pick, k, other;
  logic [2:0]    kk, nerr;

  atpg_netlist #(.NG(NG), .IW(IW)) u_net (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .kind_i(cfg_kind), .src0_i(cfg_src0), .src1_i(cfg_src1),
    .sink_i(cfg_sink), .po_i(cfg_is_out),
    .kind_q(kind_q), .src0_q(src0_q), .src1_q(src1_q),
    .sink_q(sink_q), .po_q(po_q)
  );

  atpg_lines #(.NG(NG), .IW(IW)) u_lines (
    .clk(clk), .rst_n(rst_n), .clr(accept), .we(val_we),
    .waddr(t_line), .wdata(t_val), .vals_q(vals_q)
  );

  atpg_stack #(.DEPTH(STACK_DEPTH), .W(SW)) u_stack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .pop(step_act),
    .push_n(push_n), .push_a(push_a), .push_b(push_b),
    .top_o(top_e), .empty_o(stk_empty), .ovf_o(ovf_ev)
  );

  assign accept   = start && !running;
  assign step_act = running && !stk_empty;
  assign {t_prop, t_line, t_val} = top_e;
  assign cur = vals_q[t_line];
  assign kd  = kind_q[t_line];

  // a line may be written if unassigned, or upgraded to an error of the same good value
  assign assign_ok   = (cur == LV_X) || (good_of(cur) == good_of(t_val));
  assign conflict_ev = step_act && !assign_ok;
  assign val_we      = step_act && assign_ok && ((cur == LV_X) || is_err(t_val));

  // justify operands
  assign a0    = src0_q[t_line];
  assign a1    = src1_q[t_line];
  assign inval = good_of(t_val) ^ inv_of(kd);
  assign pick  = ((vals_q[a1] == LV_X) && ((vals_q[a0] != LV_X) || (a1 < a0))) ? a1 : a0;

  // propagate operands
  assign k     = sink_q[t_line];
  assign kk    = kind_q[k];
  assign nerr  = inv_of(kk) ? flip_err(t_val) : t_val;
  assign other = (src0_q[k] == t_line) ? src1_q[k] : src0_q[k];
  assign dead_end_ev = step_act && t_prop && !po_q[t_line] && (kk == K_PI);

  always_comb begin
    push_n = 2'd0;
    push_a = '0;
    push_b = '0;
    if (accept) begin
      push_n = 2'd2;
      push_a = {1'b1, fault_line, stuck_val ? LV_DB : LV_D};
      push_b = {1'b0, fault_line, lv_of_bit(!stuck_val)};
    end else if (step_act && !conflict_ev && !dead_end_ev) begin
      if (!t_prop) begin
        if (kd == K_NOT) begin
          push_n = 2'd1;
          push_a = {1'b0, a0, lv_of_bit(inval)};
        end else if (kd != K_PI) begin
          if (inval != ctrl_of(kd)) begin
            push_n = 2'd2;
            push_a = {1'b0, a0, lv_of_bit(inval)};
            push_b = {1'b0, a1, lv_of_bit(inval)};
          end else begin
            push_n = 2'd1;
            push_a = {1'b0, pick, lv_of_bit(inval)};
          end
        end
      end else if (!po_q[t_line]) begin
        if (kk == K_NOT) begin
          push_n = 2'd1;
          push_a = {1'b1, k, nerr};
        end else begin
          push_n = 2'd2;
          push_a = {1'b1, k, nerr};
          push_b = {1'b0, other, lv_of_bit(!ctrl_of(kk))};
        end
      end
    end
  end

  assign fail_ev = conflict_ev || dead_end_ev || (step_act && ovf_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        running <= 1'b1;
        fail    <= 1'b0;
      end else if (running) begin
        if (fail_ev) begin
          running <= 1'b0;
          fail    <= 1'b1;
          done    <= 1'b1;
        end else if (stk_empty) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign busy = running;

  for (genvar i = 0; i < NG; i++) begin : g_res
    assign result[2*i +: 2] = (kind_q[i] == K_PI) ? pi_code(vals_q[i]) : 2'b10;
  end
endmodule

// File: rtl/atpg_engine_chk.sv
module atpg_engine_chk #(
  parameter int NG = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            fail,
  input logic            step_act,
  input logic            ovf_ev,
  input logic            conflict_ev,
  input logic            dead_end_ev,
  input logic [2*NG-1:0] result
);
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_fail_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);
  p_dead_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dead_end_ev |=> (fail && done));
  p_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_ev |=> (fail && done));
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_act && ovf_ev) |=> (fail && done));
  for (genvar i = 0; i < NG; i++) begin : g_code
    p_code_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
      result[2*i +: 2] != 2'b11);
  end
endmodule

bind atpg_engine atpg_engine_chk #(.NG(NG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .step_act(step_act), .ovf_ev(ovf_ev),
  .conflict_ev(conflict_ev), .dead_end_ev(dead_end_ev), .result(result)
);

// File: tb/atpg_engine_bench.sv
module atpg_engine_bench;
  localparam int NG = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_addr = '0, cfg_src0 = '0, cfg_src1 = '0, cfg_sink = '0;
  logic [2:0] cfg_kind = '0;
  logic cfg_is_out = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] fault_line = '0;
  logic stuck_val = 1'b0;
  logic busy, done, fail, busy_s, done_s, fail_s;
  logic [2*NG-1:0] result, result_s;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  atpg_engine u_atpg_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_kind(cfg_kind), .cfg_src0(cfg_src0), .cfg_src1(cfg_src1),
    .cfg_sink(cfg_sink), .cfg_is_out(cfg_is_out), .start(start),
    .fault_line(fault_line), .stuck_val(stuck_val),
    .busy(busy), .done(done), .fail(fail), .result(result)
  );

  atpg_engine #(.STACK_DEPTH(2)) u_atpg_engine_small (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_kind(cfg_kind), .cfg_src0(cfg_src0), .cfg_src1(cfg_src1),
    .cfg_sink(cfg_sink), .cfg_is_out(cfg_is_out), .start(start),
    .fault_line(fault_line), .stuck_val(stuck_val),
    .busy(busy_s), .done(done_s), .fail(fail_s), .result(result_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int kind, input int s0, input int s1,
                    input int snk, input logic po);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = IW'(a); cfg_kind = 3'(kind);
    cfg_src0 = IW'(s0); cfg_src1 = IW'(s1); cfg_sink = IW'(snk); cfg_is_out = po;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one fault and leaves the bench at the negedge where done is high
  task automatic run(input int line, input logic v);
    int n = 0;
    @(negedge clk);
    fault_line = IW'(line); stuck_val = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R13 busy after start", 32'(busy), 32'd1);
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog: no done for line %0d", line);
    end
  endtask

  // {line[3:0], stuck, codes {e,d,c,b,a}, expected fail}
  localparam logic [15:0] VEC [5] = '{
    {4'd5,  1'b0, 10'b01_00_00_01_01, 1'b0},  // R5 R7: AND s-a-0, NOR both inputs
    {4'd6,  1'b1, 10'b01_10_01_01_01, 1'b0},  // R6 R3: NOR controlling, d unassigned
    {4'd4,  1'b0, 10'b01_00_00_01_01, 1'b0},  // R4 R12: PI fault, reports good value
    {4'd9,  1'b1, 10'b01_00_00_01_01, 1'b0},  // R8: fault on the primary output
    {4'd10, 1'b0, 10'b10_10_10_10_10, 1'b1}   // R9: sink entry is a PI
  };

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 fail", 32'(fail), 32'd0);
    chk("R1 result", result, {NG{2'b10}});

    // R2 netlist: PIs 0..4, g5=AND(0,1), g6=NOR(2,3), g7=NAND(5,6), g8=NOT(4), g9=OR(7,8) output
    for (int i = 0; i < 5; i++) wr(i, 0, 0, 0, (i < 2) ? 5 : (i < 4) ? 6 : 8, 1'b0);
    wr(5, 1, 0, 1, 7, 1'b0);
    wr(6, 4, 2, 3, 7, 1'b0);
    wr(7, 3, 5, 6, 9, 1'b0);
    wr(8, 5, 4, 4, 9, 1'b0);
    wr(9, 2, 7, 8, 0, 1'b1);

    for (int t = 0; t < 5; t++) begin
      run(int'(VEC[t][15:12]), VEC[t][11]);
      chk("R4 R5 R6 R7 PI codes", 32'(result[9:0]), 32'(VEC[t][10:1]));
      chk("R8 R9 fail flag", 32'(fail), 32'(VEC[t][0]));
      if (t == 0) begin
        chk("R2 R12 non-PI and unused slots", 32'(result[31:10]), 32'({11{2'b10}}));
        chk("R11 small stack overflows", 32'(fail_s), 32'd1);
      end
      if (t == 4) chk("R9 R12 PI slot 10 justified to 1", 32'(result[21:20]), 32'd1);
      @(negedge clk);
      chk("R13 done one cycle", 32'(done), 32'd0);
      chk("R13 idle after done", 32'(busy), 32'd0);
    end

    // R10: rewire g5 into g11=OR(0,5) as output; line 0 must be 0 and 1 at once
    wr(5, 1, 0, 1, 11, 1'b0);
    wr(11, 2, 0, 5, 0, 1'b1);
    run(5, 1'b0);
    chk("R10 conflict fail", 32'(fail), 32'd1);
    chk("R12 non-PI slot 11", 32'(result[23:22]), 32'd2);

    // R3 R8: restore and rerun, fail cleared and vector fresh
    wr(5, 1, 0, 1, 7, 1'b0);
    run(8, 1'b1);
    // g8 s-a-1: e=1 (8 justified to 0), 7 to 0 -> a=b=1, c=d=0
    chk("R3 R8 fail cleared", 32'(fail), 32'd0);
    chk("R3 R4 PI codes", 32'(result[9:0]), 32'(10'b01_00_00_01_01));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule